// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block sits behind the inbound write path of a host bridge and turns message-signalled interrupts into one level-sensitive interrupt line. Software programs a 64-bit capture address. Any inbound write that hits this address exactly carries a vector number in its data word. That number raises one status bit in a set of banked 32-bit registers. There are 8 banks, so 256 vectors in all.

Software controls each bank through three registers on a simple 32-bit register port. The enable register decides whether a vector may be captured at all. The mask register decides whether a captured vector may drive the interrupt line. The status register holds the captured vectors and is cleared by writing ones. The interrupt output is high while any bank holds a status bit whose mask bit is clear.

Reads on the register port are served by a two-state response machine. `RP_IDLE` moves to `RP_RESP` when a read is requested. `RP_RESP` stays in `RP_RESP` on a back-to-back read and returns to `RP_IDLE` otherwise. The machine is in `RP_RESP` for exactly the cycle in which read data is presented.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq_out` is low and `reg_rvalid` is low.
- R2: The capture address is held in two registers: the low 32 bits at offset 0x820 and the high 32 bits at offset 0x824. Both read back what was written. An inbound write is captured only when all 64 of its address bits equal this address.
- R3: Bank i (i = 0..7) has its enable register at 0x828 + 12*i, its mask register at 0x82C + 12*i and its status register at 0x830 + 12*i. Enable and mask read back what was written.
- R4: A captured inbound write with data n (n < 256) sets status bit n%32 of bank n/32, in the clock edge that samples the write. No status bit is ever set without an inbound write.
- R5: An inbound write whose data value is 256 or more changes no status bit.
- R6: An inbound write for a vector whose enable bit is clear is dropped and leaves status unchanged.
- R7: Writing a word to a status register clears every status bit whose written bit is 1 and leaves the others unchanged. Reading a status register returns the current status.
- R8: When an inbound capture and a status clear hit the same bit in the same cycle, the bit ends up set.
- R9: `irq_out` is the OR over all banks of (status AND NOT mask), derived combinationally from the registers. A masked vector is still captured into status, and it drives `irq_out` as soon as it is unmasked.
- R10: A read request is answered in the next cycle with `reg_rvalid` high and the data on `reg_rdata`. Offsets that are not word-aligned or not mapped read as zero, and writes to them have no effect.
- R11: An inbound write whose address differs from the capture address in either the low or the high word changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Inbound write strobe |
| msg_addr | input | 64 | Inbound write address |
| msg_data | input | 32 | Inbound write data (vector number) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| irq_out | output | 1 | Summarised interrupt line |

## Verification
The assertions check several properties on every cycle: that a capture into an enabled bit always lands despite a same-cycle clear, that a bit whose enable is clear never rises, that a write-one clear takes effect when no capture competes, that no status bit rises in a cycle without an inbound write, and that each read is answered in the following cycle. Other behaviours depend on specific stimulus, so only the bench scenarios can show them. These are the exact register offset of each bank, the rejection of out-of-range vectors and of near-miss addresses, the masked-but-captured case that raises the line on unmasking, and the zero response of unaligned and unmapped offsets.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
    // register-port response machine
    typedef enum logic {
        RP_IDLE = 1'b0,
        RP_RESP = 1'b1
    } rport_state_t;
endpackage

// File: rtl/msi_bank.sv
// One bank of 32 vectors: enable, mask and write-one-to-clear status.
module msi_bank #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_we,
    input  logic         mk_we,
    input  logic         st_w1c,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set_req,
    output logic [W-1:0] enable,
    output logic [W-1:0] mask,
    output logic [W-1:0] status,
    output logic         pend
);
    logic [W-1:0] clr_bits;
    logic [W-1:0] set_bits;
    logic [W-1:0] status_nx;

    always_comb begin
        clr_bits  = st_w1c ? wdata : '0;
        set_bits  = set_req & enable;
        // capture applied after the clear, so a colliding set survives
        status_nx = (status & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
            mask   <= '0;
            status <= '0;
        end else begin
            if (en_we) enable <= wdata;
            if (mk_we) mask   <= wdata;
            status <= status_nx;
        end
    end

    assign pend = |(status & ~mask);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_req & enable)) |=> ((status & $past(set_req & enable)) == $past(set_req & enable))); // R8

    AST_DISABLED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_req) |=> ((status & ~$past(status) & ~$past(enable)) == '0)); // R6

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w1c && !(|set_req)) |=> ((status & $past(wdata)) == '0)); // R7
endmodule

// File: rtl/msi_reg_decode.sv
// Decodes a register byte offset into per-register hit strobes.
module msi_reg_decode #(
    parameter int unsigned         NB     = 8,
    parameter int unsigned         AW     = 12,
    parameter logic [AW-1:0]       BASE   = 12'h820,
    parameter int unsigned         STRIDE = 12
) (
    input  logic [AW-1:0] reg_addr,
    output logic          hit_lo,
    output logic          hit_hi,
    output logic [NB-1:0] hit_en,
    output logic [NB-1:0] hit_mk,
    output logic [NB-1:0] hit_st
);
    localparam logic [AW-1:0] LO_OFF = BASE;
    localparam logic [AW-1:0] HI_OFF = AW'(BASE + 4);

    // only exact word-aligned offsets can compare equal
    assign hit_lo = (reg_addr == LO_OFF);
    assign hit_hi = (reg_addr == HI_OFF);

    for (genvar i = 0; i < NB; i++) begin : g_bank_dec
        localparam logic [AW-1:0] EN_OFF = AW'(BASE + 8  + STRIDE * i);
        localparam logic [AW-1:0] MK_OFF = AW'(BASE + 12 + STRIDE * i);
        localparam logic [AW-1:0] ST_OFF = AW'(BASE + 16 + STRIDE * i);
        assign hit_en[i] = (reg_addr == EN_OFF);
        assign hit_mk[i] = (reg_addr == MK_OFF);
        assign hit_st[i] = (reg_addr == ST_OFF);
    end
endmodule

// File: rtl/msi_vec_decode.sv
// Matches an inbound write against the capture address and expands the
// vector number into a one-hot set request over all banks.
module msi_vec_decode #(
    parameter int unsigned NVEC = 256,
    parameter int unsigned DW   = 32
) (
    input  logic            msg_valid,
    input  logic [2*DW-1:0] msg_addr,
    input  logic [2*DW-1:0] tgt_addr,
    input  logic [DW-1:0]   msg_data,
    output logic [NVEC-1:0] set_req
);
    localparam int unsigned IDX_W = $clog2(NVEC);

    logic hit;

    assign hit = msg_valid && (msg_addr == tgt_addr) && (msg_data < DW'(NVEC));

    always_comb begin
        for (int k = 0; k < NVEC; k++) begin
            set_req[k] = hit && (msg_data[IDX_W-1:0] == IDX_W'(k));
        end
    end
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
    import msi_cap_pkg::*;
#(
    parameter int unsigned        NUM_BANKS   = 8,
    parameter int unsigned        DATA_W      = 32,
    parameter int unsigned        REG_AW      = 12,
    parameter logic [REG_AW-1:0]  CSR_BASE    = 12'h820,
    parameter int unsigned        BANK_STRIDE = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  msg_valid,
    input  logic [2*DATA_W-1:0]   msg_addr,
    input  logic [DATA_W-1:0]     msg_data,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  reg_rvalid,
    output logic                  irq_out
);
    localparam int unsigned NVEC = NUM_BANKS * DATA_W;

    logic [DATA_W-1:0]                   tgt_lo, tgt_hi;
    logic                                hit_lo, hit_hi;
    logic [NUM_BANKS-1:0]                hit_en, hit_mk, hit_st;
    logic [NUM_BANKS-1:0][DATA_W-1:0]    en_q, mk_q, st_q, set_bank;
    logic [NUM_BANKS-1:0]                pend;
    logic [NVEC-1:0]                     set_req;
    logic [DATA_W-1:0]                   rd_val, rdata_q;
    rport_state_t                        state, state_nx;

    msi_reg_decode #(
        .NB(NUM_BANKS), .AW(REG_AW), .BASE(CSR_BASE), .STRIDE(BANK_STRIDE)
    ) u_dec (
        .reg_addr(reg_addr), .hit_lo(hit_lo), .hit_hi(hit_hi),
        .hit_en(hit_en), .hit_mk(hit_mk), .hit_st(hit_st)
    );

    msi_vec_decode #(.NVEC(NVEC), .DW(DATA_W)) u_vec (
        .msg_valid(msg_valid), .msg_addr(msg_addr),
        .tgt_addr({tgt_hi, tgt_lo}), .msg_data(msg_data), .set_req(set_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_lo <= '0;
            tgt_hi <= '0;
        end else begin
            if (reg_wr && hit_lo) tgt_lo <= reg_wdata;
            if (reg_wr && hit_hi) tgt_hi <= reg_wdata;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign set_bank[b] = set_req[b*DATA_W +: DATA_W];
        msi_bank #(.W(DATA_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .en_we(reg_wr && hit_en[b]),
            .mk_we(reg_wr && hit_mk[b]),
            .st_w1c(reg_wr && hit_st[b]),
            .wdata(reg_wdata), .set_req(set_bank[b]),
            .enable(en_q[b]), .mask(mk_q[b]), .status(st_q[b]),
            .pend(pend[b])
        );
    end

    assign irq_out = |pend;

    // read mux: unmapped or unaligned offsets hit nothing and give zero
    always_comb begin
        rd_val = '0;
        if (hit_lo) rd_val = rd_val | tgt_lo;
        if (hit_hi) rd_val = rd_val | tgt_hi;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit_en[b]) rd_val = rd_val | en_q[b];
            if (hit_mk[b]) rd_val = rd_val | mk_q[b];
            if (hit_st[b]) rd_val = rd_val | st_q[b];
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RP_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RP_IDLE: state_nx = reg_rd ? RP_RESP : RP_IDLE;
            RP_RESP: state_nx = reg_rd ? RP_RESP : RP_IDLE;
            default: state_nx = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_val;
    end

    // outputs
    always_comb begin
        reg_rvalid = 1'b0;
        reg_rdata  = '0;
        unique case (state)
            RP_IDLE: ;
            RP_RESP: begin
                reg_rvalid = 1'b1;
                reg_rdata  = rdata_q;
            end
            default: ;
        endcase
    end

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid); // R10

    AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |=> ((st_q & ~$past(st_q)) == '0)); // R4

    AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rvalid |-> (reg_rdata == '0)); // R10
endmodule

// File: tb/sim_msi_capture_ctrl.sv
module sim_msi_capture_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [63:0] msg_addr = '0;
    logic [31:0] msg_data = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [63:0] TGT = 64'h0000_0001_FEE0_1000;

    always #4 clk = ~clk;

    msi_capture_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_addr(msg_addr),
        .msg_data(msg_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .irq_out(irq_out)
    );

    function automatic logic [11:0] en_off(int i); return 12'(12'h828 + 12*i); endfunction
    function automatic logic [11:0] mk_off(int i); return 12'(12'h82C + 12*i); endfunction
    function automatic logic [11:0] st_off(int i); return 12'(12'h830 + 12*i); endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R10 rvalid", {31'd0, reg_rvalid}, 32'd1);
        d = reg_rdata;
    endtask

    task automatic send(logic [63:0] a, logic [31:0] v);
        @(negedge clk);
        msg_valid = 1'b1; msg_addr = a; msg_data = v;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 8; i++) wr(st_off(i), 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq", {31'd0, irq_out}, 32'd0);
        chk("R1 rvalid", {31'd0, reg_rvalid}, 32'd0);
        rd(12'h820, d); chk("R1 lo", d, 32'd0);
        rd(en_off(0), d); chk("R1 en0", d, 32'd0);
        rd(st_off(7), d); chk("R1 st7", d, 32'd0);
    endtask

    task automatic t_addr();
        logic [31:0] d;
        wr(12'h820, TGT[31:0]);
        wr(12'h824, TGT[63:32]);
        rd(12'h820, d); chk("R2 lo", d, TGT[31:0]);
        rd(12'h824, d); chk("R2 hi", d, TGT[63:32]);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            wr(en_off(i), 32'hA500_0000 | 32'(i));
            wr(mk_off(i), 32'h005A_0000 | 32'(i));
        end
        for (int i = 0; i < 8; i++) begin
            rd(en_off(i), d); chk("R3 enable", d, 32'hA500_0000 | 32'(i));
            rd(mk_off(i), d); chk("R3 mask", d, 32'h005A_0000 | 32'(i));
        end
        for (int i = 0; i < 8; i++) begin
            wr(en_off(i), 32'hFFFF_FFFF);
            wr(mk_off(i), 32'h0);
        end
    endtask

    task automatic t_capture();
        logic [31:0] d;
        send(TGT, 32'd0);
        chk("R9 irq up", {31'd0, irq_out}, 32'd1);
        send(TGT, 32'd37);
        send(TGT, 32'd255);
        rd(st_off(0), d); chk("R4 bank0", d, 32'h0000_0001);
        rd(st_off(1), d); chk("R4 bank1", d, 32'h0000_0020);
        rd(st_off(7), d); chk("R4 bank7", d, 32'h8000_0000);
        wr(st_off(0), 32'h0000_0002);
        rd(st_off(0), d); chk("R7 zero bits kept", d, 32'h0000_0001);
        wr(st_off(0), 32'h0000_0001);
        rd(st_off(0), d); chk("R7 cleared", d, 32'h0);
        clear_all();
        chk("R9 irq down", {31'd0, irq_out}, 32'd0);
    endtask

    task automatic t_range();
        logic [31:0] d;
        send(TGT, 32'd256);
        send(TGT, 32'd1000);
        send(TGT, 32'h8000_0000);
        chk("R5 irq", {31'd0, irq_out}, 32'd0);
        rd(st_off(0), d); chk("R5 bank0", d, 32'h0);
    endtask

    task automatic t_wrong_addr();
        logic [31:0] d;
        send({32'h0, TGT[31:0]}, 32'd3);
        send({TGT[63:32], TGT[31:0] ^ 32'h4}, 32'd3);
        chk("R11 irq", {31'd0, irq_out}, 32'd0);
        rd(st_off(0), d); chk("R11 bank0", d, 32'h0);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        wr(en_off(2), 32'hFFFF_FFFE);
        send(TGT, 32'd64);
        rd(st_off(2), d); chk("R6 dropped", d, 32'h0);
        send(TGT, 32'd65);
        rd(st_off(2), d); chk("R6 enabled neighbour", d, 32'h2);
        clear_all();
        wr(en_off(2), 32'hFFFF_FFFF);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(mk_off(3), 32'h0000_0010);
        send(TGT, 32'd100);
        chk("R9 masked irq", {31'd0, irq_out}, 32'd0);
        rd(st_off(3), d); chk("R9 masked captured", d, 32'h0000_0010);
        wr(mk_off(3), 32'h0);
        chk("R9 unmasked irq", {31'd0, irq_out}, 32'd1);
        clear_all();
        chk("R9 cleared irq", {31'd0, irq_out}, 32'd0);
    endtask

    task automatic t_race();
        logic [31:0] d;
        send(TGT, 32'd128);
        @(negedge clk);
        msg_valid = 1'b1; msg_addr = TGT; msg_data = 32'd128;
        reg_wr = 1'b1; reg_addr = st_off(4); reg_wdata = 32'h0000_0001;
        @(negedge clk);
        msg_valid = 1'b0; reg_wr = 1'b0;
        rd(st_off(4), d); chk("R8 set wins", d, 32'h0000_0001);
        @(negedge clk);
        msg_valid = 1'b1; msg_addr = TGT; msg_data = 32'd129;
        reg_wr = 1'b1; reg_addr = st_off(4); reg_wdata = 32'h0000_0001;
        @(negedge clk);
        msg_valid = 1'b0; reg_wr = 1'b0;
        rd(st_off(4), d); chk("R8 other bit", d, 32'h0000_0002);
        clear_all();
    endtask

    task automatic t_unaligned();
        logic [31:0] d;
        wr(12'h829, 32'h0);
        rd(en_off(0), d); chk("R10 unaligned write", d, 32'hFFFF_FFFF);
        rd(12'h829, d); chk("R10 unaligned read", d, 32'h0);
        rd(12'h700, d); chk("R10 unmapped read", d, 32'h0);
        @(negedge clk);
        chk("R10 rvalid drops", {31'd0, reg_rvalid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_addr();
        t_layout();
        t_capture();
        t_range();
        t_wrong_addr();
        t_disabled();
        t_mask();
        t_race();
        t_unaligned();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule